// File: doc/BRIEF.md
# Link Receive Responder with Frame CRC Check

This block sits on the receive side of a serial storage link. A remote transmitter asks to send with a ready request. The block answers each incoming decoded dword with a response primitive, one per cycle. It collects the data dwords that arrive between the start and end delimiters of one frame and removes the scrambling from each of them. It then checks the last dword of the frame as a CRC over everything before it, and reports the result when the transmitter asks for the final status.

The payload goes out as a simple valid/last stream, and the CRC dword is removed from it. Because a dword can only be known to be the CRC once the end delimiter has arrived, the block keeps the two most recent descrambled dwords in reserve. Downstream logic that is running short of space raises a pause request. The block then answers data with the hold primitive instead of the in-progress primitive, so that the remote side slows down. Dwords that are already in flight are still accepted.

Top module: `link_rx_responder`

## Requirements
- R1: A dword is a primitive only when `rx_ctrl` is 1. The codes are: SYNC 0x010101BC, X_RDY 0x020202BC, R_RDY 0x030303BC, SOF 0x040404BC, EOF 0x050505BC, WTRM 0x060606BC, R_IP 0x070707BC, R_OK 0x080808BC, R_ERR 0x090909BC, HOLD 0x0A0A0ABC, HOLDA 0x0B0B0BBC. After reset, `tx_prim` is SYNC and `pl_valid` is 0. Outside a frame, any input other than X_RDY, HOLD, SOF or WTRM gets a SYNC response, and this includes plain data and unknown control codes.
- R2: X_RDY gets an R_RDY response in the next cycle, whether or not `pause_req` is set.
- R3: HOLD gets a HOLDA response in the next cycle, both inside and outside a frame.
- R4: SOF opens a frame and gets an R_IP response. Inside a frame, data dwords are captured. Control dwords inside a frame, other than EOF, WTRM, HOLD and X_RDY, are not stored and do not appear as payload.
- R5: Inside a frame, every response other than the HOLDA of R3 is HOLD while `pause_req` is 1 and R_IP while it is 0. Data is still captured while `pause_req` is 1.
- R6: The k-th data dword of a frame (k = 0, 1, ...) is XORed with key k. Key 0 is 0x1F2E3D4C and is restored at each SOF. Key k+1 is key k shifted left by one, XORed with 0x00400007 when bit 31 of key k was 1.
- R7: The last descrambled dword of a frame is the CRC and is never emitted. All earlier dwords are emitted in order on `pl_data`. Each is emitted one cycle after the dword two positions later arrives, or one cycle after EOF for the final payload dword, which also carries `pl_last`.
- R8: The CRC is CRC-32 with polynomial 0x04C11DB7 and initial value 0x52325032. It is unreflected, has no final XOR, and shifts in whole dwords MSB first. The final payload beat has `pl_crc_ok` equal to 1 when the CRC matches and 0 otherwise. Beats that are not last have `pl_crc_ok` at 1.
- R9: WTRM gets R_OK in the next cycle if the last frame closed by EOF had a matching CRC. Otherwise it gets R_ERR, which is also the answer when no EOF has been seen since reset or since the last SOF. WTRM ends the frame.
- R10: EOF gets the same response as a data dword. A frame that holds only the CRC dword emits no payload beat, and its result is still reported by R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 32 | Decoded receive dword |
| rx_ctrl | input | 1 | Receive dword is a control primitive |
| pause_req | input | 1 | Downstream asks the peer to be held |
| tx_prim | output | 32 | Response primitive sent back to the peer |
| pl_valid | output | 1 | Payload beat present |
| pl_data | output | 32 | Descrambled payload dword |
| pl_last | output | 1 | Final payload beat of the frame |
| pl_crc_ok | output | 1 | CRC result, meaningful with pl_last |

## Verification
Every response primitive is due exactly one clock after the dword that causes it. A payload beat comes one clock after the data dword that pushes it out of the two-deep reserve, and the final beat comes one clock after EOF. The bench drives each dword on a falling edge and samples the outputs on the next falling edge, so every check lands in the single cycle where that result must appear. Payload beats are collected at the same point and compared after WTRM against a frame that the bench built and scrambled itself.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
    localparam int DW = 32;

    localparam logic [DW-1:0] P_SYNC  = 32'h0101_01BC;
    localparam logic [DW-1:0] P_XRDY  = 32'h0202_02BC;
    localparam logic [DW-1:0] P_RRDY  = 32'h0303_03BC;
    localparam logic [DW-1:0] P_SOF   = 32'h0404_04BC;
    localparam logic [DW-1:0] P_EOF   = 32'h0505_05BC;
    localparam logic [DW-1:0] P_WTRM  = 32'h0606_06BC;
    localparam logic [DW-1:0] P_RIP   = 32'h0707_07BC;
    localparam logic [DW-1:0] P_ROK   = 32'h0808_08BC;
    localparam logic [DW-1:0] P_RERR  = 32'h0909_09BC;
    localparam logic [DW-1:0] P_HOLD  = 32'h0A0A_0ABC;
    localparam logic [DW-1:0] P_HOLDA = 32'h0B0B_0BBC;

    typedef struct packed {
        logic          in_frame;
        logic          h0_v;
        logic          h1_v;
        logic [DW-1:0] h0;
        logic [DW-1:0] h1;
        logic          stat_ok;
        logic [DW-1:0] rsp;
        logic          pl_v;
        logic [DW-1:0] pl_d;
        logic          pl_l;
        logic          pl_ok;
    } rx_state_t;

    function automatic logic [DW-1:0] crc_dword(input logic [DW-1:0] c,
                                                input logic [DW-1:0] d,
                                                input logic [DW-1:0] poly);
        logic [DW-1:0] r;
        r = c ^ d;
        for (int i = 0; i < DW; i++)
            r = r[DW-1] ? ((r << 1) ^ poly) : (r << 1);
        return r;
    endfunction

    function automatic logic [DW-1:0] key_next(input logic [DW-1:0] s,
                                               input logic [DW-1:0] taps);
        return s[DW-1] ? ({s[DW-2:0], 1'b0} ^ taps) : {s[DW-2:0], 1'b0};
    endfunction
endpackage

// File: rtl/lrx_descrambler.sv
module lrx_descrambler
    import lrx_pkg::*;
#(
    parameter logic [DW-1:0] SEED = 32'h1F2E_3D4C,
    parameter logic [DW-1:0] TAPS = 32'h0040_0007
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    output logic [DW-1:0] key_o
);
    logic [DW-1:0] key_d, key_q;

    always_comb begin
        key_d = key_q;
        if (restart)      key_d = SEED;
        else if (advance) key_d = key_next(key_q, TAPS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) key_q <= SEED;
        else        key_q <= key_d;
    end

    assign key_o = key_q;

    // R6
    key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> key_o == SEED);
endmodule

// File: rtl/lrx_crc_acc.sv
module lrx_crc_acc
    import lrx_pkg::*;
#(
    parameter logic [DW-1:0] INIT = 32'h5232_5032,
    parameter logic [DW-1:0] POLY = 32'h04C1_1DB7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          update,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] crc_o
);
    logic [DW-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear)       crc_d = INIT;
        else if (update) crc_d = crc_dword(crc_q, din, POLY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    // R8
    crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> crc_o == INIT);
endmodule

// File: rtl/link_rx_responder.sv
module link_rx_responder
    import lrx_pkg::*;
#(
    parameter logic [31:0] SCR_SEED = 32'h1F2E_3D4C,
    parameter logic [31:0] SCR_TAPS = 32'h0040_0007,
    parameter logic [31:0] CRC_INIT = 32'h5232_5032,
    parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] rx_data,
    input  logic        rx_ctrl,
    input  logic        pause_req,
    output logic [31:0] tx_prim,
    output logic        pl_valid,
    output logic [31:0] pl_data,
    output logic        pl_last,
    output logic        pl_crc_ok
);
    localparam rx_state_t RST_ST = '{in_frame: 1'b0, h0_v: 1'b0, h1_v: 1'b0,
                                     h0: '0, h1: '0, stat_ok: 1'b0,
                                     rsp: P_SYNC, pl_v: 1'b0, pl_d: '0,
                                     pl_l: 1'b0, pl_ok: 1'b0};

    rx_state_t     st_d, st_q;
    logic          sof_hit, data_hit, crc_upd;
    logic [DW-1:0] key, crc_now;

    lrx_descrambler #(.SEED(SCR_SEED), .TAPS(SCR_TAPS)) u_dscr (
        .clk(clk), .rst_n(rst_n), .restart(sof_hit), .advance(data_hit),
        .key_o(key));

    lrx_crc_acc #(.INIT(CRC_INIT), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear(sof_hit), .update(crc_upd),
        .din(st_q.h0), .crc_o(crc_now));

    always_comb begin
        st_d       = st_q;
        st_d.pl_v  = 1'b0;
        st_d.pl_l  = 1'b0;
        st_d.pl_ok = 1'b1;
        sof_hit    = 1'b0;
        data_hit   = 1'b0;
        crc_upd    = 1'b0;
        if (rx_ctrl && rx_data == P_HOLD) begin
            st_d.rsp = P_HOLDA;
        end else if (rx_ctrl && rx_data == P_XRDY) begin
            st_d.rsp = P_RRDY;
        end else if (rx_ctrl && rx_data == P_SOF) begin
            st_d.rsp      = P_RIP;
            st_d.in_frame = 1'b1;
            st_d.h0_v     = 1'b0;
            st_d.h1_v     = 1'b0;
            st_d.stat_ok  = 1'b0;
            sof_hit       = 1'b1;
        end else if (rx_ctrl && rx_data == P_WTRM) begin
            st_d.rsp      = st_q.stat_ok ? P_ROK : P_RERR;
            st_d.in_frame = 1'b0;
        end else if (st_q.in_frame) begin
            st_d.rsp = pause_req ? P_HOLD : P_RIP;
            if (!rx_ctrl) begin
                data_hit = 1'b1;
                if (st_q.h1_v) begin
                    st_d.pl_v = 1'b1;
                    st_d.pl_d = st_q.h1;
                end
                if (st_q.h0_v) begin
                    st_d.h1   = st_q.h0;
                    st_d.h1_v = 1'b1;
                    crc_upd   = 1'b1;
                end
                st_d.h0   = rx_data ^ key;
                st_d.h0_v = 1'b1;
            end else if (rx_data == P_EOF) begin
                st_d.in_frame = 1'b0;
                st_d.stat_ok  = st_q.h0_v && (st_q.h0 == crc_now);
                if (st_q.h1_v) begin
                    st_d.pl_v  = 1'b1;
                    st_d.pl_d  = st_q.h1;
                    st_d.pl_l  = 1'b1;
                    st_d.pl_ok = st_q.h0_v && (st_q.h0 == crc_now);
                end
                st_d.h0_v = 1'b0;
                st_d.h1_v = 1'b0;
            end
        end else begin
            st_d.rsp = P_SYNC;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign tx_prim   = st_q.rsp;
    assign pl_valid  = st_q.pl_v;
    assign pl_data   = st_q.pl_d;
    assign pl_last   = st_q.pl_l;
    assign pl_crc_ok = st_q.pl_ok;

    // R2
    rdy_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ctrl && rx_data == P_XRDY) |=> tx_prim == P_RRDY);
    // R3
    hold_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ctrl && rx_data == P_HOLD) |=> tx_prim == P_HOLDA);
    // R9
    wtrm_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ctrl && rx_data == P_WTRM) |=> (tx_prim == P_ROK || tx_prim == P_RERR));
    // R7
    beat_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid |-> $past(!rx_ctrl || rx_data == P_EOF));
    // R7
    last_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_last |-> ($past(rx_ctrl && rx_data == P_EOF) && pl_valid));
    // R4
    no_beat_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ctrl && rx_data != P_EOF) |=> !pl_valid);
endmodule

// File: tb/sim_link_rx_responder.sv
module sim_link_rx_responder;
    import lrx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rx_data = P_SYNC;
    logic        rx_ctrl = 1'b1;
    logic        pause_req = 1'b0;
    logic [31:0] tx_prim;
    logic        pl_valid, pl_last, pl_crc_ok;
    logic [31:0] pl_data;

    int          nchk = 0, nfail = 0, ncap = 0;
    bit          done = 0;
    logic [31:0] rsp_s;
    logic [31:0] cap_d [0:15];
    logic        cap_l [0:15];
    logic        cap_k [0:15];

    always #2 clk = ~clk;

    link_rx_responder u0 (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
        .pause_req(pause_req), .tx_prim(tx_prim), .pl_valid(pl_valid),
        .pl_data(pl_data), .pl_last(pl_last), .pl_crc_ok(pl_crc_ok));

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r = c ^ w;
        int n = 0;
        while (n < 32) begin
            if (r[31]) r = (r << 1) ^ 32'h04C1_1DB7;
            else       r = r << 1;
            n++;
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_key(input logic [31:0] k);
        logic [31:0] t = k << 1;
        if (k[31]) t = t ^ 32'h0040_0007;
        return t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic [31:0] d, input logic p);
        rx_ctrl = c; rx_data = d; pause_req = p;
        @(negedge clk);
        rsp_s = tx_prim;
        if (pl_valid && ncap < 16) begin
            cap_d[ncap] = pl_data; cap_l[ncap] = pl_last; cap_k[ncap] = pl_crc_ok;
            ncap++;
        end
    endtask

    task automatic frame(input int n, input bit corrupt, input bit pz, input bit junk);
        logic [31:0] pl [0:7];
        logic [31:0] crc = 32'h5232_5032;
        logic [31:0] key = 32'h1F2E_3D4C;
        ncap = 0;
        step(1, P_SOF, 0);
        check("R4 SOF reply", rsp_s, P_RIP);
        for (int k = 0; k < n; k++) begin
            pl[k] = 32'hA500_0000 + k * 32'h0103_0507 + n;
            crc = ref_crc(crc, pl[k]);
            step(0, pl[k] ^ key, pz);
            check(pz ? "R5 paused data reply" : "R4 data reply", rsp_s, pz ? P_HOLD : P_RIP);
            key = ref_key(key);
            if (junk && k == 0) begin
                step(1, 32'h0C0C_0CBC, 0);
                check("R4 unknown ctrl in frame", rsp_s, P_RIP);
            end
        end
        step(0, (crc ^ (corrupt ? 32'h1 : 32'h0)) ^ key, 0);
        step(1, P_EOF, 0);
        check("R10 EOF reply", rsp_s, P_RIP);
        step(1, P_WTRM, 0);
        check("R9 status", rsp_s, corrupt ? P_RERR : P_ROK);
        check("R7 beat count", ncap, n);
        for (int k = 0; k < n && k < ncap; k++) begin
            check("R6 payload data", cap_d[k], pl[k]);
            check("R7 last flag", {31'b0, cap_l[k]}, {31'b0, k == n - 1});
            check("R8 crc_ok", {31'b0, cap_k[k]}, {31'b0, (k == n - 1) ? !corrupt : 1'b1});
        end
    endtask

    // {ctrl, pause, data, expected response}
    localparam logic [65:0] VEC [0:13] = '{
        {1'b1, 1'b0, P_SYNC,       P_SYNC},
        {1'b1, 1'b0, P_XRDY,       P_RRDY},
        {1'b0, 1'b0, 32'h1234_5678, P_SYNC},
        {1'b1, 1'b0, 32'h0C0C_0CBC, P_SYNC},
        {1'b1, 1'b0, P_HOLD,       P_HOLDA},
        {1'b1, 1'b0, P_WTRM,       P_RERR},
        {1'b1, 1'b1, P_XRDY,       P_RRDY},
        {1'b1, 1'b0, P_SOF,        P_RIP},
        {1'b0, 1'b0, 32'hDEAD_BEEF, P_RIP},
        {1'b0, 1'b1, 32'h0BAD_F00D, P_HOLD},
        {1'b1, 1'b0, P_HOLD,       P_HOLDA},
        {1'b1, 1'b1, P_EOF,        P_HOLD},
        {1'b1, 1'b0, P_WTRM,       P_RERR},
        {1'b1, 1'b0, P_SYNC,       P_SYNC}
    };

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset tx_prim", tx_prim, P_SYNC);
        check("R1 reset pl_valid", {31'b0, pl_valid}, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 14; i++) begin
            step(VEC[i][65], VEC[i][63:32], VEC[i][64]);
            check("R1/R2/R3/R5 vector reply", rsp_s, VEC[i][31:0]);
        end
        frame(4, 0, 0, 0);
        frame(4, 1, 0, 0);
        frame(3, 0, 1, 1);
        frame(1, 0, 0, 0);
        frame(0, 0, 0, 0);
        frame(0, 1, 0, 0);
        // reset in the middle of a frame
        step(1, P_SOF, 0);
        step(0, 32'h5555_AAAA, 0);
        rst_n = 1'b0;
        step(1, P_SYNC, 0);
        check("R1 mid-frame reset tx_prim", rsp_s, P_SYNC);
        check("R1 mid-frame reset pl_valid", {31'b0, pl_valid}, 32'h0);
        rst_n = 1'b1;
        step(0, 32'h0000_0001, 0);
        check("R1 idle after reset", rsp_s, P_SYNC);
        step(1, P_WTRM, 0);
        check("R9 WTRM after reset", rsp_s, P_RERR);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule